// File: doc/BRIEF.md
# Audio Buffer DMA Controller

This block is the register-facing half of an audio playback path. Software places a buffer address into one register and then writes a byte count into another. The count write is the trigger. It takes the current address and count, places them as one descriptor in a two-entry queue, and starts the transfer engine if the engine is idle. Software can keep one buffer playing while the next one waits in the queue.

The engine models how long each buffer takes to play out. A buffer holds stereo frames of two 16-bit samples, so each frame is 4 bytes. The engine emits one frame every (divider + 1) clock cycles and presents the frame's memory address. The 32-bit word returned from memory is passed to the sample output with the two bytes of each 16-bit half exchanged.

When a buffer finishes, the block raises a level interrupt and moves to the next queued buffer with no gap. A descriptor with a count of zero finishes without producing any frames. Writing the status register acknowledges the interrupt.

Top module: `snd_dma_ctrl`

## Requirements
- R1: After reset every register reads 0, the queue is empty, the engine is idle, `irq` is low and `frame_vld` is low.
- R2: The register index is `reg_ofs[4:2]` and offset bits 1:0 are ignored. The indices are: 0 divider, 1 bit-rate, 2 control, 3 status, 4 buffer address, 5 byte count. A write to index 4 keeps only bits 23:3, so a read returns the written value ANDed with 0x00FFFFF8.
- R3: A write to index 5 keeps only bits 17:3 (mask 0x0003FFF8). A read of index 5 returns the stored count only while the queue is full, and returns 0 at all other times.
- R4: A write to index 5 while two descriptors are queued updates the stored count but adds no descriptor. Such a write produces no extra frames and no extra completion.
- R5: While two descriptors are held, status bits 31 and 0 both read 1. Both read 0 once a completion leaves fewer than two descriptors.
- R6: Status bit 30 reads 1 from the clock edge that starts a descriptor until the edge on which the last queued descriptor completes. All other status bits read 0.
- R7: For an active descriptor of L bytes and divider value D, `frame_vld` pulses for one cycle at the end of every run of D+1 cycles, starting from the load edge. There are L/4 pulses in total, and the descriptor completes on the edge that ends its last pulse.
- R8: During a frame pulse, `mem_addr` equals the descriptor address plus 4 times the number of frames already emitted for that descriptor.
- R9: `frame_data` equals `mem_rdata` with bytes 31:24 and 23:16 exchanged and bytes 15:8 and 7:0 exchanged.
- R10: A descriptor whose count is 0 completes on the edge after it is loaded. It produces no frame pulse.
- R11: Every completion sets `irq`, which stays high until a write to index 3 clears it. If a completion and a status write happen on the same edge, the completion wins. A status write does not change the status value read back.
- R12: The divider register keeps bits 13:0 and the bit-rate register keeps bits 3:0. The control register keeps all 32 bits. Indices 6 and 7 read 0.
- R13: Descriptors complete in the order they were written. When a descriptor completes with another one queued (including one written on that same edge), the next descriptor is loaded on that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_ofs | input | 5 | Register byte offset, used for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_ofs`, combinational |
| mem_addr | output | 24 | Memory byte address of the current frame |
| mem_rdata | input | 32 | Memory word returned for `mem_addr` |
| frame_vld | output | 1 | One-cycle pulse per frame emitted |
| frame_data | output | 32 | Frame word with the bytes of each half exchanged |
| irq | output | 1 | Completion interrupt level |

## Verification
The bench builds the block with its default parameters: a 24-bit address, an 18-bit count and a 14-bit divider. It keeps descriptors short and programs divider values of 5, 1 and 0. With those values each buffer finishes within a few dozen cycles. That brings the following cases within a short run:
- a full queue and a rejected third count write;
- a hand-off where a completion and a new count write land on the same edge;
- a status clear swept across the completion edge.

A behavioural model built on a queue follows every cycle and compares the interrupt, the frame strobe, the address, the swapped data and the read data.

// File: rtl/snd_dma_pkg.sv
`timescale 1ns/1ps
package snd_dma_pkg;

  localparam int DW    = 32;
  localparam int OFS_W = 5;

  typedef enum logic [2:0] {
    IDX_RATE  = 3'd0,
    IDX_BRATE = 3'd1,
    IDX_CTRL  = 3'd2,
    IDX_STAT  = 3'd3,
    IDX_ADDR  = 3'd4,
    IDX_LEN   = 3'd5
  } reg_idx_e;

  // exchange the two bytes inside each 16-bit half
  function automatic logic [DW-1:0] halfword_swap(input logic [DW-1:0] w);
    return {w[23:16], w[31:24], w[7:0], w[15:8]};
  endfunction

  // full shows on bit 31 and bit 0, busy on bit 30
  function automatic logic [DW-1:0] status_word(input logic full, input logic busy);
    logic [DW-1:0] s;
    s     = '0;
    s[31] = full;
    s[30] = busy;
    s[0]  = full;
    return s;
  endfunction

endpackage

// File: rtl/snd_dma_regs.sv
`timescale 1ns/1ps
module snd_dma_regs
  import snd_dma_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int LEN_W   = 18,
  parameter int RATE_W  = 14,
  parameter int BRATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DW-1:0]     wdata,
  input  logic              q_full,
  input  logic              q_busy,
  output logic [DW-1:0]     rdata,
  output logic              len_wr,
  output logic              stat_wr,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LEN_W-1:0]  len_new,
  output logic [RATE_W-1:0] rate_q
);

  logic [2:0]         idx;
  logic [LEN_W-1:0]   len_q;
  logic [DW-1:0]      ctrl_q;
  logic [BRATE_W-1:0] brate_q;
  logic               unused_ofs_lo;

  assign idx           = ofs[OFS_W-1:2];
  assign unused_ofs_lo = ^ofs[1:0];
  assign len_new       = {wdata[LEN_W-1:3], 3'b000};
  assign len_wr        = wr_en && (idx == IDX_LEN);
  assign stat_wr       = wr_en && (idx == IDX_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      len_q   <= '0;
      ctrl_q  <= '0;
      rate_q  <= '0;
      brate_q <= '0;
    end else if (wr_en) begin
      case (idx)
        IDX_RATE:  rate_q  <= wdata[RATE_W-1:0];
        IDX_BRATE: brate_q <= wdata[BRATE_W-1:0];
        IDX_CTRL:  ctrl_q  <= wdata;
        IDX_ADDR:  addr_q  <= {wdata[ADDR_W-1:3], 3'b000};
        IDX_LEN:   len_q   <= len_new;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      IDX_RATE:  rdata = DW'(rate_q);
      IDX_BRATE: rdata = DW'(brate_q);
      IDX_CTRL:  rdata = ctrl_q;
      IDX_STAT:  rdata = status_word(q_full, q_busy);
      IDX_ADDR:  rdata = DW'(addr_q);
      IDX_LEN:   rdata = q_full ? DW'(len_q) : '0;
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/snd_dma_queue.sv
`timescale 1ns/1ps
module snd_dma_queue #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [LEN_W-1:0]  push_len,
  output logic [1:0]        cnt,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic [LEN_W-1:0]  nxt_len
);

  localparam int SLOTS = 2;

  logic [ADDR_W-1:0] slot_addr [SLOTS];
  logic [LEN_W-1:0]  slot_len  [SLOTS];
  logic              wi, ri;

  // slot after the head: the one that loads when the head completes
  assign nxt_addr = slot_addr[~ri];
  assign nxt_len  = slot_len[~ri];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++) begin
        slot_addr[s] <= '0;
        slot_len[s]  <= '0;
      end
    end else if (push) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (wi == 1'(s)) begin
          slot_addr[s] <= push_addr;
          slot_len[s]  <= push_len;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wi  <= 1'b0;
      ri  <= 1'b0;
      cnt <= 2'd0;
    end else begin
      if (push) wi <= ~wi;
      if (pop)  ri <= ~ri;
      case ({push, pop})
        2'b10:   cnt <= cnt + 2'd1;
        2'b01:   cnt <= cnt - 2'd1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/snd_dma_xfer.sv
`timescale 1ns/1ps
module snd_dma_xfer #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 18,
  parameter int RATE_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic [RATE_W-1:0] rate,
  output logic              busy,
  output logic              frame_evt,
  output logic              done_evt,
  output logic [ADDR_W-1:0] cur_addr
);

  localparam int FRM_W = LEN_W - 2;

  logic [FRM_W-1:0]  frames_q;
  logic [RATE_W-1:0] div_q;
  logic              last_frame;
  logic              unused_len_lo;

  // 4 bytes per stereo frame
  function automatic logic [FRM_W-1:0] frames_in(input logic [LEN_W-1:0] len);
    return len[LEN_W-1:2];
  endfunction

  assign unused_len_lo = ^ld_len[1:0];
  assign frame_evt     = busy && (frames_q != '0) && (div_q == '0);
  assign last_frame    = (frames_q == FRM_W'(1));
  assign done_evt      = busy && ((frames_q == '0) || (frame_evt && last_frame));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      frames_q <= '0;
      div_q    <= '0;
      cur_addr <= '0;
    end else if (load) begin
      busy     <= 1'b1;
      frames_q <= frames_in(ld_len);
      div_q    <= rate;
      cur_addr <= ld_addr;
    end else if (done_evt) begin
      busy     <= 1'b0;
    end else if (frame_evt) begin
      frames_q <= frames_q - FRM_W'(1);
      div_q    <= rate;
      cur_addr <= cur_addr + ADDR_W'(4);
    end else if (busy) begin
      div_q    <= div_q - RATE_W'(1);
    end
  end

endmodule

// File: rtl/snd_dma_ctrl.sv
`timescale 1ns/1ps
module snd_dma_ctrl
  import snd_dma_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int LEN_W   = 18,
  parameter int RATE_W  = 14,
  parameter int BRATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [OFS_W-1:0]  reg_ofs,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DW-1:0]     mem_rdata,
  output logic              frame_vld,
  output logic [DW-1:0]     frame_data,
  output logic              irq
);

  // named internal events, also seen by the bound checker
  logic              len_wr_evt, stat_wr_evt, push_evt, done_evt, frame_evt;
  logic              busy, full, more_left, load_evt;
  logic [1:0]        entry_cnt;
  logic [ADDR_W-1:0] addr_q, nxt_addr, cur_addr, ld_addr;
  logic [LEN_W-1:0]  len_new, nxt_len, ld_len;
  logic [RATE_W-1:0] rate_q;

  assign full      = (entry_cnt == 2'd2);
  assign push_evt  = len_wr_evt && !full;
  assign more_left = full || ((entry_cnt == 2'd1) && push_evt);
  assign load_evt  = (push_evt && !busy) || (done_evt && more_left);
  // a descriptor written this edge is loaded straight from the bus
  assign ld_addr   = push_evt ? addr_q  : nxt_addr;
  assign ld_len    = push_evt ? len_new : nxt_len;

  snd_dma_regs #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .RATE_W(RATE_W), .BRATE_W(BRATE_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .ofs(reg_ofs), .wdata(reg_wdata),
    .q_full(full), .q_busy(busy), .rdata(reg_rdata),
    .len_wr(len_wr_evt), .stat_wr(stat_wr_evt),
    .addr_q(addr_q), .len_new(len_new), .rate_q(rate_q)
  );

  snd_dma_queue #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(push_evt), .pop(done_evt),
    .push_addr(addr_q), .push_len(len_new), .cnt(entry_cnt),
    .nxt_addr(nxt_addr), .nxt_len(nxt_len)
  );

  snd_dma_xfer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .RATE_W(RATE_W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .load(load_evt), .ld_addr(ld_addr), .ld_len(ld_len),
    .rate(rate_q), .busy(busy), .frame_evt(frame_evt), .done_evt(done_evt),
    .cur_addr(cur_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           irq <= 1'b0;
    else if (done_evt)    irq <= 1'b1;
    else if (stat_wr_evt) irq <= 1'b0;
  end

  assign mem_addr   = cur_addr;
  assign frame_vld  = frame_evt;
  assign frame_data = halfword_swap(mem_rdata);

endmodule

// File: rtl/snd_dma_ctrl_chk.sv
`timescale 1ns/1ps
module snd_dma_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       push_evt,
  input logic       done_evt,
  input logic       stat_wr_evt,
  input logic       busy,
  input logic       irq,
  input logic [1:0] entry_cnt
);

  // R4
  cnt_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_cnt != 2'd3);

  // R4
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_cnt == 2'd2 && !done_evt) |=> entry_cnt == 2'd2);

  // R13
  cnt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_evt && !done_evt) |=> entry_cnt == $past(entry_cnt) + 2'd1);

  // R6
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_evt && !busy) |=> busy);

  // R6
  last_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && entry_cnt == 2'd1 && !push_evt) |=> !busy);

  // R11
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> irq);

  // R11
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr_evt && !done_evt) |=> !irq);

endmodule

bind snd_dma_ctrl snd_dma_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .push_evt(push_evt), .done_evt(done_evt),
  .stat_wr_evt(stat_wr_evt), .busy(busy), .irq(irq), .entry_cnt(entry_cnt)
);

// File: tb/snd_dma_ctrl_bench.sv
`timescale 1ns/1ps
module snd_dma_ctrl_bench;

  logic        clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [4:0]  reg_ofs = '0;
  logic [31:0] reg_wdata = '0, mem_rdata = 32'h1357_9BDF;
  logic [31:0] reg_rdata, frame_data;
  logic [23:0] mem_addr;
  logic        frame_vld, irq;

  snd_dma_ctrl u_snd_dma_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_ofs(reg_ofs),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .frame_vld(frame_vld), .frame_data(frame_data),
    .irq(irq)
  );

  always #2 clk = ~clk; // 250 MHz

  int n_chk = 0, n_err = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int unsigned fq_a[$], fq_l[$], seen[$];
  bit          m_busy, m_irq, mp, msw, mf, md, was_busy, ef;
  int          m_frames, m_div, midx;
  int unsigned m_cur, m_addr, m_len, m_ctrl, m_rate, m_brate;

  function automatic void start_head();
    m_busy   = 1'b1;
    m_frames = int'(fq_l[0] / 4);
    m_div    = int'(m_rate);
    m_cur    = fq_a[0];
  endfunction

  function automatic logic [31:0] exp_read(input int i);
    bit full;
    full = (fq_a.size() == 2);
    case (i)
      0: return m_rate;
      1: return m_brate;
      2: return m_ctrl;
      3: return {full, m_busy, 29'd0, full};
      4: return m_addr;
      5: return full ? m_len : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string rd_tag(input int i);
    case (i)
      3: return "R6 status read";
      4: return "R2 address read";
      5: return "R3 length read";
      default: return "R12 register read";
    endcase
  endfunction

  function automatic logic [31:0] bswap(input logic [31:0] w);
    logic [31:0] o;
    for (int h = 0; h < 2; h++) begin
      o[16*h +: 8]     = w[16*h + 8 +: 8];
      o[16*h + 8 +: 8] = w[16*h +: 8];
    end
    return o;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      fq_a.delete(); fq_l.delete();
      m_busy = 0; m_irq = 0; m_frames = 0; m_div = 0; m_cur = 0;
      m_addr = 0; m_len = 0; m_ctrl = 0; m_rate = 0; m_brate = 0;
    end else begin
      midx     = int'(reg_ofs >> 2);
      mp       = reg_wr && midx == 5 && fq_a.size() != 2;
      msw      = reg_wr && midx == 3;
      mf       = m_busy && m_frames != 0 && m_div == 0;
      md       = m_busy && (m_frames == 0 || (mf && m_frames == 1));
      was_busy = m_busy;
      if (mp) begin
        fq_a.push_back(m_addr);
        fq_l.push_back(reg_wdata & 32'h0003_FFF8);
      end
      if (md) begin
        void'(fq_a.pop_front()); void'(fq_l.pop_front());
        m_irq = 1'b1;
        if (fq_a.size() > 0) start_head(); else m_busy = 1'b0;
      end else if (mp && !was_busy) start_head();
      else if (mf) begin
        m_frames--; m_div = int'(m_rate); m_cur += 4;
      end else if (m_busy) m_div--;
      if (msw && !md) m_irq = 1'b0;
      if (reg_wr) begin
        case (midx)
          0: m_rate  = reg_wdata & 32'h3FFF;
          1: m_brate = reg_wdata & 32'hF;
          2: m_ctrl  = reg_wdata;
          4: m_addr  = reg_wdata & 32'h00FF_FFF8;
          5: m_len   = reg_wdata & 32'h0003_FFF8;
          default: ;
        endcase
      end
    end
    #1;
    if (rst_n) begin
      check("R11 irq level", irq, m_irq);
      ef = m_busy && m_frames != 0 && m_div == 0;
      check("R7 frame strobe", frame_vld, ef);
      if (ef) begin
        check("R8 frame address", mem_addr, m_cur & 32'h00FF_FFFF);
        check("R9 byte swap", frame_data, bswap(mem_rdata));
      end
      if (frame_vld) seen.push_back(mem_addr);
      check(rd_tag(int'(reg_ofs >> 2)), reg_rdata, exp_read(int'(reg_ofs >> 2)));
    end
  end

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_ofs = 5'(idx * 4); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input int idx, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_ofs = 5'(idx * 4 + 3);
    #1 check(tag, reg_rdata, exp);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      mem_rdata = mem_rdata * 32'd1103515245 + 32'd12345;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < 8; i++) rd_chk(i, 32'd0, "R1 reset read");
    check("R1 reset irq", irq, 1'b0);
    check("R1 reset frame", frame_vld, 1'b0);

    // R12 register widths
    wr(0, 32'hFFFF_C005); rd_chk(0, 32'h5, "R12 divider mask");
    wr(1, 32'hFFFF_FFF5); rd_chk(1, 32'h5, "R12 bit-rate mask");
    wr(2, 32'hDEAD_BEEF); rd_chk(2, 32'hDEAD_BEEF, "R12 control word");
    rd_chk(6, 32'd0, "R12 unmapped index 6");
    rd_chk(7, 32'd0, "R12 unmapped index 7");

    // R2 address mask
    wr(4, 32'hFF12_3457); rd_chk(4, 32'h0012_3450, "R2 address mask");

    // R5 R6 R3 R4: two queued, third rejected
    seen.delete();
    wr(5, 32'h0000_0017);
    rd_chk(3, 32'h4000_0000, "R6 busy only");
    rd_chk(5, 32'd0, "R3 length hidden when not full");
    wr(4, 32'h0000_0200);
    wr(5, 32'h0000_0008);
    rd_chk(3, 32'hC000_0001, "R5 full bits");
    rd_chk(5, 32'h8, "R3 length visible when full");
    wr(5, 32'h0000_0020);
    rd_chk(5, 32'h20, "R4 length updated while full");
    rd_chk(3, 32'hC000_0001, "R4 still two entries");
    repeat (50) @(negedge clk);
    rd_chk(3, 32'd0, "R6 idle after last");
    check("R11 irq after completion", irq, 1'b1);
    check("R4 no extra frames", seen.size(), 6);
    if (seen.size() == 6) begin
      check("R13 order f0", seen[0], 32'h12_3450);
      check("R8 step f1",   seen[1], 32'h12_3454);
      check("R8 step f2",   seen[2], 32'h12_3458);
      check("R8 step f3",   seen[3], 32'h12_345C);
      check("R13 order f4", seen[4], 32'h200);
      check("R8 step f5",   seen[5], 32'h204);
    end

    // R11 clear by status write
    wr(3, 32'hFFFF_FFFF);
    #1 check("R11 cleared", irq, 1'b0);
    rd_chk(3, 32'd0, "R11 status unchanged");

    // R10 zero length
    wr(4, 32'h0000_0400);
    seen.delete();
    wr(5, 32'd0);
    #1 check("R10 not yet done", irq, 1'b0);
    @(negedge clk);
    #1 check("R10 done next edge", irq, 1'b1);
    rd_chk(3, 32'd0, "R10 idle");
    check("R10 no frames", seen.size(), 0);
    wr(3, 32'd0);

    // R11 clear swept across the completion edge
    wr(0, 32'd0);
    for (int k = 0; k < 6; k++) begin
      wr(5, 32'h8);
      repeat (k) @(negedge clk);
      wr(3, 32'd0);
      repeat (4) @(negedge clk);
    end

    // R13 back-to-back hand-off with varied spacing
    wr(0, 32'd1);
    for (int k = 0; k < 4; k++) begin
      wr(4, 32'h1000 + 32'(k) * 32'h40);
      wr(5, 32'h8 + 32'(k) * 32'h8);
      repeat (k) @(negedge clk);
    end
    repeat (80) @(negedge clk);
    rd_chk(3, 32'd0, "R13 queue drained");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule